// File: doc/BRIEF.md
# Burst SRAM Address Control

This block holds the address register and the 2-bit burst counter at the front of a synchronous burst SRAM. On each rising clock edge it samples an address bus, two active-low address strobes, three chip enables and an active-low advance input. One strobe belongs to the processor and the other to the controller. When a strobe is accepted and every chip enable is active, the full address is latched, the low two bits seed the burst counter, and a chip-selected flag is set. When a strobe is accepted while any chip enable is inactive, the selected flag clears and the stored address is left as it was.

Between strobes, the advance input steps the counter through a four-beat burst. A static strap chooses the order of the beats. Linear order counts up modulo 4. Interleaved order XORs the starting value with a step count. The output address is built from the stored upper bits and the counter, and both the address and the selected flag come straight from flip-flops. The memory array, the data path, sleep mode and boundary scan are handled elsewhere.

Top module: `bsram_addr_ctl`

## Requirements
- R1: After synchronous reset, `sel_q` is 0 and `addr_q` is all zeros, which includes a counter value of 0.
- R2: A strobe is accepted when `proc_strb_n` is low with `en1_n` low, or when `ctrl_strb_n` is low. When a strobe is accepted and all enables are active (`en1_n`=0, `en2`=1, `en3_n`=0), then after that edge `addr_q` equals the sampled `addr_in` and `sel_q` is 1.
- R3: When both strobes are low in the same cycle with all enables active, exactly one load takes place, with the same result as the processor strobe alone.
- R4: While `en1_n` is high, a low `proc_strb_n` has no effect. With `ctrl_strb_n` high, the address and flag hold when `adv_n` is high, and the counter advances when `adv_n` is low.
- R5: A strobe accepted while any enable is inactive sets `sel_q` to 0 and leaves `addr_q` unchanged. This includes a controller strobe while `en1_n` is high.
- R6: With `order_strap`=0 (linear), each edge with `adv_n` low and no accepted strobe sets `addr_q[1:0]` to its previous value plus 1 modulo 4. A burst from 1 therefore runs 1,2,3,0.
- R7: With `order_strap`=1 (interleaved), the k-th advance after a load gives `addr_q[1:0]` = start XOR k (mod 4). A burst from 1 therefore runs 1,0,3,2, and a burst from 3 runs 3,2,1,0.
- R8: With no accepted strobe and `adv_n` high, `addr_q` and `sel_q` hold their values.
- R9: An accepted strobe takes precedence over a low `adv_n` in the same cycle, so the counter loads instead of stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Address bus |
| proc_strb_n | input | 1 | Processor address strobe, active low, gated by `en1_n` |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| en1_n | input | 1 | Chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_strap | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| addr_q | output | ADDR_W | Registered address; low CNT_W bits come from the burst counter |
| sel_q | output | 1 | Registered chip-selected flag |

## Verification
Full bursts are run from start values 1 and 3 in both orders. Those start values give different sequences in linear and interleaved order, so a swapped or broken order shows up. A start value of 2 is also run in linear order to check the wrap from 3 back to 0. Strobe patterns try each strobe alone, both together, the processor strobe with its own enable off (with advance both high and low), and a controller strobe with each of the other enables off; these separate the gating, the priority and the deselect paths. Further cycles combine a strobe with a low advance, and idle cycles with advance high, to confirm that a load wins over a step and that the state holds.

// File: rtl/bsram_addr_pkg.sv
package bsram_addr_pkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/bsram_strobe_dec.sv
module bsram_strobe_dec (
  input  logic proc_strb_n,
  input  logic ctrl_strb_n,
  input  logic en1_n,
  input  logic en2,
  input  logic en3_n,
  output logic take,
  output logic chips_on
);

  logic proc_take;
  logic ctrl_take;

  // The processor strobe only counts while the first enable is active.
  // When both strobes are low the processor wins; both paths do the same load.
  always_comb begin
    proc_take = ~proc_strb_n & ~en1_n;
    ctrl_take = ~ctrl_strb_n & ~proc_take;
    take      = proc_take | ctrl_take;
    chips_on  = ~en1_n & en2 & ~en3_n;
  end

endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
  import bsram_addr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step_en,
  input  burst_order_e     order,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] low_q
);

  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] step_nx;
  logic [CNT_W-1:0] low_nx;

  assign step_nx = step_q + ONE;

  always_comb begin
    if (order == ORDER_INTERLEAVED) low_nx = start_q ^ step_nx;
    else                            low_nx = low_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      step_q  <= '0;
      low_q   <= '0;
    end else if (load) begin
      start_q <= start_val;
      step_q  <= '0;
      low_q   <= start_val;
    end else if (step_en) begin
      step_q  <= step_nx;
      low_q   <= low_nx;
    end
  end

  // R6: linear order counts up by one, wrapping modulo 2**CNT_W
  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    (order == ORDER_LINEAR && step_en && !load) |=> low_q == $past(low_q) + ONE);

  // R7: interleaved order changes the low bits by (k-1) XOR k
  assert_interleave_step_R7: assert property (@(posedge clk) disable iff (rst)
    (order == ORDER_INTERLEAVED && step_en && !load)
      |=> (low_q ^ $past(low_q)) == ($past(step_q) ^ ($past(step_q) + ONE)));

  // R9: a load wins over a step request
  assert_load_first_R9: assert property (@(posedge clk) disable iff (rst)
    (load && step_en) |=> low_q == $past(start_val));

endmodule

// File: rtl/bsram_addr_ctl.sv
module bsram_addr_ctl
  import bsram_addr_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              adv_n,
  input  logic              order_strap,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_q
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic            take;
  logic            chips_on;
  logic            load;
  logic            step_en;
  logic [HI_W-1:0] hi_q;
  logic [CNT_W-1:0] low_q;

  bsram_strobe_dec u_dec (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .en1_n       (en1_n),
    .en2         (en2),
    .en3_n       (en3_n),
    .take        (take),
    .chips_on    (chips_on)
  );

  assign load    = take & chips_on;
  assign step_en = ~take & ~adv_n;

  bsram_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step_en   (step_en),
    .order     (burst_order_e'(order_strap)),
    .start_val (addr_in[CNT_W-1:0]),
    .low_q     (low_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      sel_q <= 1'b0;
    end else if (take) begin
      sel_q <= chips_on;
      if (chips_on) hi_q <= addr_in[ADDR_W-1:CNT_W];
    end
  end

  assign addr_q = {hi_q, low_q};

  // R1: the edge after a reset cycle leaves everything cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sel_q && addr_q == '0));

  // R2: an accepted strobe with every enable on captures the address
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !en1_n && en2 && !en3_n) |=> (sel_q && addr_q == $past(addr_in)));

  // R3: both strobes low with enables on still makes one clean load
  assert_both_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && !ctrl_strb_n && !en1_n && en2 && !en3_n)
      |=> (sel_q && addr_q == $past(addr_in)));

  // R4: a gated processor strobe with advance high changes nothing
  assert_proc_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && en1_n && ctrl_strb_n && adv_n)
      |=> ($stable(addr_q) && $stable(sel_q)));

  // R5: an accepted strobe with an enable off deselects and keeps the address
  assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
    (take && !chips_on) |=> (!sel_q && $stable(addr_q)));

  // R8: idle cycles hold the state
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && ctrl_strb_n && adv_n) |=> ($stable(addr_q) && $stable(sel_q)));

endmodule

// File: tb/bsram_addr_ctl_tb.sv
module bsram_addr_ctl_tb;

  localparam int AW = 18;
  localparam int CW = 2;

  typedef struct {
    logic [AW-1:0] addr;
    logic          sel;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_strb_n = 1'b1;
  logic          ctrl_strb_n = 1'b1;
  logic          en1_n = 1'b1;
  logic          en2 = 1'b0;
  logic          en3_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_strap = 1'b0;
  logic [AW-1:0] addr_q;
  logic          sel_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  // bench model state
  logic [AW-1:0] m_addr  = '0;
  logic [CW-1:0] m_start = '0;
  logic [CW-1:0] m_step  = '0;
  logic          m_sel   = 1'b0;

  always #10 clk = ~clk;

  bsram_addr_ctl #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk (clk), .rst (rst), .addr_in (addr_in),
    .proc_strb_n (proc_strb_n), .ctrl_strb_n (ctrl_strb_n),
    .en1_n (en1_n), .en2 (en2), .en3_n (en3_n),
    .adv_n (adv_n), .order_strap (order_strap),
    .addr_q (addr_q), .sel_q (sel_q)
  );

  task automatic drive(input logic [AW-1:0] a, input logic p_n, input logic c_n,
                       input logic e1n, input logic e2v, input logic e3n,
                       input logic av_n, input logic ord, input string tag);
    logic acc;
    logic on;
    exp_t it;
    @(negedge clk);
    addr_in = a; proc_strb_n = p_n; ctrl_strb_n = c_n;
    en1_n = e1n; en2 = e2v; en3_n = e3n; adv_n = av_n; order_strap = ord;
    acc = (!p_n && !e1n) || !c_n;
    on  = !e1n && e2v && !e3n;
    if (acc) begin
      m_sel = on;
      if (on) begin
        m_addr  = a;
        m_start = a[CW-1:0];
        m_step  = '0;
      end
    end else if (!av_n) begin
      m_step = m_step + 1'b1;
      if (ord) m_addr[CW-1:0] = m_start ^ m_step;
      else     m_addr[CW-1:0] = m_addr[CW-1:0] + 1'b1;
    end
    it.addr = m_addr; it.sel = m_sel; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare after each edge that has an expected item
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (addr_q !== it.addr || sel_q !== it.sel) begin
        fails++;
        $display("FAIL %s: addr_q=%h sel_q=%b expected addr_q=%h sel_q=%b",
                 it.tag, addr_q, sel_q, it.addr, it.sel);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (addr_q !== '0 || sel_q !== 1'b0) begin
      fails++;
      $display("FAIL R1: addr_q=%h sel_q=%b expected addr_q=0 sel_q=0", addr_q, sel_q);
    end
    // R2 + R6: processor load at start 2, linear wrap
    drive(18'h01232, 0, 1, 0, 1, 0, 1, 0, "R2");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    // R8: idle hold
    drive(18'h3FFFF, 1, 1, 1, 0, 1, 1, 0, "R8");
    drive(18'h2AAAA, 1, 1, 0, 1, 0, 1, 0, "R8");
    // R3: both strobes at start 1, then linear burst 2,3,0
    drive(18'h2A5D1, 0, 0, 0, 1, 0, 1, 0, "R3");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    // R7: interleaved from 1 -> 0,3,2
    drive(18'h15551, 1, 0, 0, 1, 0, 1, 1, "R2");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 1, "R7");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 1, "R7");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 1, "R7");
    // R7: interleaved from 3 -> 2,1,0
    drive(18'h0F0F3, 0, 1, 0, 1, 0, 1, 1, "R2");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 1, "R7");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 1, "R7");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 1, "R7");
    // R6: linear from 3 -> 0
    drive(18'h0F0F3, 0, 1, 0, 1, 0, 1, 0, "R2");
    drive(18'h00000, 1, 1, 0, 1, 0, 0, 0, "R6");
    // R4: gated processor strobe, advance high then low
    drive(18'h3FFFC, 0, 1, 1, 1, 0, 1, 0, "R4");
    drive(18'h3FFFC, 0, 1, 1, 1, 0, 0, 0, "R4");
    // R9: load with advance low at the same edge
    drive(18'h12342, 0, 1, 0, 1, 0, 0, 0, "R9");
    // R5: controller strobe with en2 off, then with en1_n high
    drive(18'h3C3C1, 1, 0, 0, 0, 0, 1, 0, "R5");
    drive(18'h00000, 1, 1, 0, 1, 0, 1, 0, "R8");
    drive(18'h11111, 0, 1, 0, 1, 0, 1, 0, "R2");
    drive(18'h2BCD3, 0, 0, 1, 1, 0, 1, 0, "R5");
    drive(18'h22222, 1, 0, 0, 1, 1, 0, 0, "R5");
    // R4 with deselected flag: advance still steps
    drive(18'h00000, 0, 1, 1, 1, 0, 0, 0, "R4");
    drive(18'h00000, 1, 1, 1, 1, 1, 1, 0, "R8");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule